// File: doc/BRIEF.md
# Banked Dual-Port Byte Memory

This block is a byte-wide memory with two independent access ports, left and right. Each port has its own address, active-low chip select, read/write strobe (low means write), active-low output enable, active-low semaphore select and data lines. The storage is split into equal sub-banks. Each port takes the upper bits of its own address and decodes them locally into a one-hot sub-bank select. The lower bits pick a row inside the selected sub-bank. Because each port has its own decoder, the two ports can work in different sub-banks in the same cycle.

The block runs on one clock that stands in for the asynchronous strobes. A write lands at the clock edge. Read data, and the flag that says the port drives its data lines, appear in the following cycle. Each data output is a value plus a drive-enable instead of a tri-state line.

A depopulated build halves the number of sub-banks. In that build the top address bit must stay low. An access with that bit high falls into no sub-bank and is treated as deselected. There is no arbitration between the ports, and semaphore flags are handled outside this block. When both ports write the same location in the same cycle, this model lets the left port win.

Top module: `banked_dpram`

## Requirements
- R1: With chip select low, read/write low and semaphore select high, the port's input byte is stored at its address at that clock edge, and the port does not drive its data lines in the next cycle.
- R2: With chip select low, read/write high, output enable low and semaphore select high, the port drives its drive-enable high one cycle later with the byte stored at that address. The drive-enable falls again one cycle after the read strobe ends.
- R3: With chip select low, read/write high and output enable high, the drive-enable is low one cycle later and memory is unchanged.
- R4: With chip select high, the port is deselected whatever read/write and output enable do. Nothing is written, and the drive-enable is low one cycle later.
- R5: With chip select low and semaphore select low at once, the port makes no memory access. Nothing is written, and the drive-enable is low one cycle later.
- R6: Address bits [BANK_AW +: SEL_W] choose the sub-bank and bits [BANK_AW-1:0] choose the row. Every address of the full build maps to its own location.
- R7: The two ports act independently in the same cycle, in the same or in different sub-banks and at different rows.
- R8: When both ports write the same location in the same cycle, the left port's byte is the one kept.
- R9: When one port reads a location in the same cycle that the other port writes it, the read returns the contents from before that write.
- R10: With DEPOP set, only the lower half of the sub-banks exists. An access whose sub-bank field points past them writes nothing, and a read of such an address leaves the drive-enable low.
- R11: While reset is low at a clock edge, both drive-enables and both output bytes are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock standing in for the access strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| l_cs_n | input | 1 | Left chip select, active low |
| l_rw_n | input | 1 | Left read/write: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore select, active low; must be high for memory access |
| l_addr | input | BANK_AW+SEL_W | Left byte address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data |
| l_dout_oe | output | 1 | Left drive-enable for l_dout |
| r_cs_n | input | 1 | Right chip select, active low |
| r_rw_n | input | 1 | Right read/write: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low; must be high for memory access |
| r_addr | input | BANK_AW+SEL_W | Right byte address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data |
| r_dout_oe | output | 1 | Right drive-enable for r_dout |

## Verification
Every port result is due exactly one clock after the cycle whose controls produced it: read data, the drive-enable rising on a read, and the drive-enable falling for a write, an output-disabled read, a deselect or a semaphore conflict. A write becomes visible to a read issued in the next cycle or later. A read issued in the same cycle as the write still returns the old byte. The bench drives each cycle's controls after a falling edge and queues one expectation per port, tagged with the following cycle. The monitor pops each expectation at the falling edge after the rising edge that registered it. Expected bytes come from a reference array in the bench. The array is updated only after that cycle's read expectations are taken, and the right port's write is applied before the left port's.

// File: rtl/dpm_pkg.sv
// Package: shared types for the banked dual-port memory.
// Assumes: nothing; holds only the per-port operation encoding.
package dpm_pkg;

    // Decoded action of one port in one cycle.
    typedef enum logic [1:0] {
        OP_DESEL  = 2'd0,   // no access, outputs released
        OP_WRITE  = 2'd1,   // store input byte
        OP_READ   = 2'd2,   // fetch byte and drive it next cycle
        OP_OUTOFF = 2'd3    // selected for read, output disabled
    } port_op_e;

endpackage

// File: rtl/dpm_ctrl.sv
// Module: per-port control decode.
// Turns the active-low strobes of one port into one operation.
// Assumes: sel_ok tells whether the address falls in a populated sub-bank;
// a combined chip select and semaphore select means no memory access.
module dpm_ctrl
    import dpm_pkg::*;
(
    input  logic     cs_n,
    input  logic     rw_n,
    input  logic     oe_n,
    input  logic     sem_n,
    input  logic     sel_ok,
    output port_op_e op
);

    // Purpose: map strobe levels to the port operation.
    always_comb begin
        op = OP_DESEL;
        if (!cs_n && sem_n && sel_ok) begin
            if (!rw_n) begin
                op = OP_WRITE;
            end else if (!oe_n) begin
                op = OP_READ;
            end else begin
                op = OP_OUTOFF;
            end
        end
    end

endmodule

// File: rtl/dpm_bank_dec.sv
// Module: sub-bank decoder.
// Turns the sub-bank field of an address into a one-hot select over the
// populated sub-banks.
// Assumes: NUM_BANKS <= 2**SEL_W; a field value past the populated range
// yields an all-zero select and valid low.
module dpm_bank_dec #(
    parameter int SEL_W     = 3,
    parameter int NUM_BANKS = 8
) (
    input  logic [SEL_W-1:0]     bank_field,
    output logic [NUM_BANKS-1:0] bank_sel,
    output logic                 valid
);

    // Purpose: compare the field against each sub-bank index.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_sel[b] = (int'(bank_field) == b);
        end
        valid = |bank_sel;
    end

endmodule

// File: rtl/dpm_subbank.sv
// Module: one sub-bank of storage with two write and two read paths.
// Reads are combinational from the array; writes land at the clock edge.
// Assumes: port A is the left port; on a same-row double write the A write
// is applied last and so wins. The array is not reset.
module dpm_subbank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a_en,
    input  logic [ROW_W-1:0]  wr_a_row,
    input  logic [DATA_W-1:0] wr_a_data,
    input  logic              wr_b_en,
    input  logic [ROW_W-1:0]  wr_b_row,
    input  logic [DATA_W-1:0] wr_b_data,
    input  logic [ROW_W-1:0]  rd_a_row,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ROW_W-1:0]  rd_b_row,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int DEPTH = 2 ** ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store writes, right first and left last so left wins.
    always_ff @(posedge clk) begin
        if (wr_b_en) begin
            mem[wr_b_row] <= wr_b_data;
        end
        if (wr_a_en) begin
            mem[wr_a_row] <= wr_a_data;
        end
    end

    // Purpose: combinational fetch for both ports (old data during a write).
    assign rd_a_data = mem[rd_a_row];
    assign rd_b_data = mem[rd_b_row];

    // R8 and R1: after a left write, the row holds the left byte.
    a_r8_left_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a_en |=> mem[$past(wr_a_row)] == $past(wr_a_data));

    // R1: a lone right write is stored.
    a_r1_right_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b_en && !(wr_a_en && wr_a_row == wr_b_row))
        |=> mem[$past(wr_b_row)] == $past(wr_b_data));

endmodule

// File: rtl/dpm_port.sv
// Module: one access port.
// Decodes the strobes and the sub-bank field, steers writes to one
// sub-bank, picks that sub-bank's read byte and registers the output byte
// and its drive-enable.
// Assumes: bank_rd carries every sub-bank's byte at this port's row;
// synchronous active-low reset clears the output register.
module dpm_port
    import dpm_pkg::*;
#(
    parameter int BANK_AW   = 6,
    parameter int SEL_W     = 3,
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cs_n,
    input  logic                             rw_n,
    input  logic                             oe_n,
    input  logic                             sem_n,
    input  logic [BANK_AW+SEL_W-1:0]         addr,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd,
    output logic [NUM_BANKS-1:0]             wr_sel,
    output logic [BANK_AW-1:0]               row,
    output logic [DATA_W-1:0]                dout,
    output logic                             dout_oe
);

    logic [NUM_BANKS-1:0] bank_sel;
    logic                 sel_ok;
    port_op_e             op;
    logic [DATA_W-1:0]    rd_byte;

    dpm_bank_dec #(
        .SEL_W     (SEL_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .bank_field (addr[BANK_AW +: SEL_W]),
        .bank_sel   (bank_sel),
        .valid      (sel_ok)
    );

    dpm_ctrl u_ctrl (
        .cs_n   (cs_n),
        .rw_n   (rw_n),
        .oe_n   (oe_n),
        .sem_n  (sem_n),
        .sel_ok (sel_ok),
        .op     (op)
    );

    assign row = addr[BANK_AW-1:0];

    // Purpose: raise the write select of the addressed sub-bank only.
    always_comb begin
        wr_sel = (op == OP_WRITE) ? bank_sel : '0;
    end

    // Purpose: pick the addressed sub-bank's byte.
    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_byte = rd_byte | (bank_rd[b] & {DATA_W{bank_sel[b]}});
        end
    end

    // Purpose: register the read byte and its drive-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= (op == OP_READ);
            if (op == OP_READ) begin
                dout <= rd_byte;
            end
        end
    end

    // R1: a write reaches exactly one sub-bank and drives nothing next cycle.
    a_r1_write_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |-> $onehot(wr_sel));
    a_r1_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sem_n && !rw_n) |=> !dout_oe);

    // R2: a valid read drives the port next cycle.
    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sem_n && rw_n && !oe_n && sel_ok) |=> dout_oe);

    // R3: output disabled keeps the lines released.
    a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw_n && oe_n) |=> !dout_oe);

    // R4: deselect releases the lines and writes nothing.
    a_r4_desel: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe);
    a_r4_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (wr_sel == '0));

    // R5: semaphore select with chip select makes no access.
    a_r5_sem_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sem_n) |=> !dout_oe);

    // R10: an address past the populated sub-banks is ignored.
    a_r10_hole_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |-> (wr_sel == '0));
    a_r10_hole_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |=> !dout_oe);

endmodule

// File: rtl/banked_dpram.sv
// Module: banked dual-port byte memory (top).
// Two independent ports share NUM_BANKS sub-banks of 2**BANK_AW bytes.
// Each port decodes its own sub-bank field.
// Assumes: no arbitration; same-location double writes keep the left byte;
// with DEPOP set the top address bit must be held low.
module banked_dpram #(
    parameter int BANK_AW = 6,
    parameter int SEL_W   = 3,
    parameter int DATA_W  = 8,
    parameter bit DEPOP   = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     l_cs_n,
    input  logic                     l_rw_n,
    input  logic                     l_oe_n,
    input  logic                     l_sem_n,
    input  logic [BANK_AW+SEL_W-1:0] l_addr,
    input  logic [DATA_W-1:0]        l_din,
    output logic [DATA_W-1:0]        l_dout,
    output logic                     l_dout_oe,
    input  logic                     r_cs_n,
    input  logic                     r_rw_n,
    input  logic                     r_oe_n,
    input  logic                     r_sem_n,
    input  logic [BANK_AW+SEL_W-1:0] r_addr,
    input  logic [DATA_W-1:0]        r_din,
    output logic [DATA_W-1:0]        r_dout,
    output logic                     r_dout_oe
);

    localparam int NUM_BANKS = DEPOP ? (2 ** (SEL_W - 1)) : (2 ** SEL_W);

    logic [NUM_BANKS-1:0]             l_wr_sel, r_wr_sel;
    logic [BANK_AW-1:0]               l_row, r_row;
    logic [NUM_BANKS-1:0][DATA_W-1:0] l_bank_rd, r_bank_rd;

    dpm_port #(
        .BANK_AW (BANK_AW), .SEL_W (SEL_W),
        .NUM_BANKS (NUM_BANKS), .DATA_W (DATA_W)
    ) u_left (
        .clk (clk), .rst_n (rst_n),
        .cs_n (l_cs_n), .rw_n (l_rw_n), .oe_n (l_oe_n), .sem_n (l_sem_n),
        .addr (l_addr), .bank_rd (l_bank_rd),
        .wr_sel (l_wr_sel), .row (l_row),
        .dout (l_dout), .dout_oe (l_dout_oe)
    );

    dpm_port #(
        .BANK_AW (BANK_AW), .SEL_W (SEL_W),
        .NUM_BANKS (NUM_BANKS), .DATA_W (DATA_W)
    ) u_right (
        .clk (clk), .rst_n (rst_n),
        .cs_n (r_cs_n), .rw_n (r_rw_n), .oe_n (r_oe_n), .sem_n (r_sem_n),
        .addr (r_addr), .bank_rd (r_bank_rd),
        .wr_sel (r_wr_sel), .row (r_row),
        .dout (r_dout), .dout_oe (r_dout_oe)
    );

    // One sub-bank per populated select line.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        dpm_subbank #(
            .ROW_W  (BANK_AW),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_a_en   (l_wr_sel[g]),
            .wr_a_row  (l_row),
            .wr_a_data (l_din),
            .wr_b_en   (r_wr_sel[g]),
            .wr_b_row  (r_row),
            .wr_b_data (r_din),
            .rd_a_row  (l_row),
            .rd_a_data (l_bank_rd[g]),
            .rd_b_row  (r_row),
            .rd_b_data (r_bank_rd[g])
        );
    end

    // R7: the ports never block each other; two reads both drive.
    a_r7_both_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && l_sem_n && l_rw_n && !l_oe_n && !DEPOP &&
         !r_cs_n && r_sem_n && r_rw_n && !r_oe_n) |=> (l_dout_oe && r_dout_oe));

    // R11: reset leaves both ports released.
    a_r11_reset_release: assert property (@(posedge clk)
        !rst_n |=> (!l_dout_oe && !r_dout_oe));

endmodule

// File: tb/banked_dpram_tb.sv
`timescale 1ns/1ps
module banked_dpram_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    // Index 0: left of full build, 1: right of full build, 2: left of half build.
    logic [2:0] cs_n, rw_n, oe_n, sem_n;
    logic [8:0] addr [3];
    logic [7:0] din  [3];
    logic [7:0] dout [3];
    logic [2:0] doe;
    logic [7:0] h_rdout;
    logic       h_rdoe;

    banked_dpram u_dut (
        .clk (clk), .rst_n (rst_n),
        .l_cs_n (cs_n[0]), .l_rw_n (rw_n[0]), .l_oe_n (oe_n[0]), .l_sem_n (sem_n[0]),
        .l_addr (addr[0]), .l_din (din[0]), .l_dout (dout[0]), .l_dout_oe (doe[0]),
        .r_cs_n (cs_n[1]), .r_rw_n (rw_n[1]), .r_oe_n (oe_n[1]), .r_sem_n (sem_n[1]),
        .r_addr (addr[1]), .r_din (din[1]), .r_dout (dout[1]), .r_dout_oe (doe[1])
    );

    banked_dpram #(.DEPOP (1'b1)) u_dut_half (
        .clk (clk), .rst_n (rst_n),
        .l_cs_n (cs_n[2]), .l_rw_n (rw_n[2]), .l_oe_n (oe_n[2]), .l_sem_n (sem_n[2]),
        .l_addr (addr[2]), .l_din (din[2]), .l_dout (dout[2]), .l_dout_oe (doe[2]),
        .r_cs_n (1'b1), .r_rw_n (1'b1), .r_oe_n (1'b1), .r_sem_n (1'b1),
        .r_addr (9'd0), .r_din (8'd0), .r_dout (h_rdout), .r_dout_oe (h_rdoe)
    );

    typedef struct {
        int         due;
        int         port;
        bit         oe;
        logic [7:0] data;
        int         req;
    } exp_t;

    exp_t       sb_q [$];
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] full_mem [512];
    logic [7:0] half_mem [512];
    bit         exp_oe [3];
    logic [7:0] exp_d  [3];
    int         exp_r  [3];
    bit         pw_en  [3];
    logic [8:0] pw_a   [3];
    logic [7:0] pw_d   [3];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare expectations that fall due at this falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (doe[it.port] !== it.oe || (it.oe && dout[it.port] !== it.data)) begin
                n_bad++;
                $display("FAIL R%0d port %0d cycle %0d: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                         it.req, it.port, cyc, doe[it.port], dout[it.port], it.oe, it.data);
            end
        end
    end

    // Start a cycle: every port idle, default expectation is released (R4).
    task automatic begin_cycle();
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            cs_n[p] = 1'b1; rw_n[p] = 1'b1; oe_n[p] = 1'b1; sem_n[p] = 1'b1;
            exp_oe[p] = 1'b0; exp_d[p] = 8'h00; exp_r[p] = 4; pw_en[p] = 1'b0;
        end
    endtask

    // kind: 1 write, 2 read, 3 read with output disabled, 4 write with
    // semaphore select low, 5 write strobes with chip select high.
    task automatic drv(int p, int kind, logic [8:0] a, logic [7:0] d, int r);
        bit ok;
        ok = (p < 2) || !a[8];
        addr[p] = a; din[p] = d; exp_r[p] = r;
        case (kind)
            1: begin
                cs_n[p] = 1'b0; rw_n[p] = 1'b0;
                pw_en[p] = ok; pw_a[p] = a; pw_d[p] = d;
            end
            2: begin
                cs_n[p] = 1'b0; oe_n[p] = 1'b0;
                exp_oe[p] = ok;
                exp_d[p] = (p < 2) ? full_mem[a] : half_mem[a];
            end
            3: begin
                cs_n[p] = 1'b0;
            end
            4: begin
                cs_n[p] = 1'b0; rw_n[p] = 1'b0; sem_n[p] = 1'b0;
            end
            default: begin
                rw_n[p] = 1'b0; oe_n[p] = 1'b0;
            end
        endcase
    endtask

    // Queue this cycle's expectations, then apply writes (right, then left).
    task automatic end_cycle();
        for (int p = 0; p < 3; p++) begin
            exp_t it;
            it.due = cyc + 1; it.port = p; it.oe = exp_oe[p];
            it.data = exp_d[p]; it.req = exp_r[p];
            sb_q.push_back(it);
        end
        if (pw_en[2]) half_mem[pw_a[2]] = pw_d[2];
        if (pw_en[1]) full_mem[pw_a[1]] = pw_d[1];
        if (pw_en[0]) full_mem[pw_a[0]] = pw_d[0];
    endtask

    task automatic one(int p, int kind, logic [8:0] a, logic [7:0] d, int r);
        begin_cycle(); drv(p, kind, a, d, r); end_cycle();
    endtask

    initial begin
        for (int p = 0; p < 3; p++) begin
            cs_n[p] = 1'b1; rw_n[p] = 1'b1; oe_n[p] = 1'b1; sem_n[p] = 1'b1;
            addr[p] = '0; din[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: released during reset.
        n_cmp++;
        if (doe !== 3'b000 || dout[0] !== 8'h00 || dout[1] !== 8'h00) begin
            n_bad++;
            $display("FAIL R11 reset: got oe=%03b l=%02h r=%02h, expected oe=000 l=00 r=00",
                     doe, dout[0], dout[1]);
        end
        rst_n = 1'b1;

        // R6, R7: both ports write every sub-bank at different rows together.
        for (int b = 0; b < 8; b++) begin
            begin_cycle();
            drv(0, 1, {3'(b), 6'(b * 5)}, 8'hA0 + 8'(b), 1);
            drv(1, 1, {3'(7 - b), 6'd63}, 8'h50 + 8'(b), 7);
            end_cycle();
        end
        // R6: read back across sub-banks, ports in parallel (R7).
        for (int b = 0; b < 8; b++) begin
            begin_cycle();
            drv(0, 2, {3'(7 - b), 6'd63}, 8'h00, 6);
            drv(1, 2, {3'(b), 6'(b * 5)}, 8'h00, 6);
            end_cycle();
        end
        // R2: drive-enable falls one cycle after the last read.
        one(0, 0, 9'd0, 8'h00, 2);
        one(1, 0, 9'd0, 8'h00, 2);

        // R9: left reads while right writes the same location.
        begin_cycle();
        drv(0, 2, 9'h0C5, 8'h00, 9);
        drv(1, 1, 9'h0C5, 8'h3C, 9);
        end_cycle();
        one(0, 2, 9'h0C5, 8'h00, 1);   // R1: new byte visible next cycle

        // R8: both write the same location; left byte kept.
        begin_cycle();
        drv(0, 1, 9'h1FE, 8'h11, 8);
        drv(1, 1, 9'h1FE, 8'h22, 8);
        end_cycle();
        one(1, 2, 9'h1FE, 8'h00, 8);

        // R3: output disabled releases lines; memory unchanged.
        one(0, 3, 9'h1FE, 8'h00, 3);
        one(1, 2, 9'h1FE, 8'h00, 3);

        // R5: semaphore conflict makes no write.
        one(0, 4, 9'h0C5, 8'hEE, 5);
        one(0, 2, 9'h0C5, 8'h00, 5);

        // R4: write strobes without chip select store nothing.
        one(1, 5, 9'h1FE, 8'h99, 4);
        one(1, 2, 9'h1FE, 8'h00, 4);

        // R10: half build stores in the low half and ignores the hole.
        one(2, 1, 9'h045, 8'h5A, 10);
        one(2, 1, 9'h145, 8'hC3, 10);
        one(2, 2, 9'h045, 8'h00, 10);
        one(2, 2, 9'h145, 8'h00, 10);
        one(2, 2, 9'h0FF, 8'h00, 10);

        begin_cycle(); end_cycle();
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 queue: got %0d pending, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got still running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule